// File: doc/BRIEF.md
# Exception Entry Controller

This block takes exceptions into a 32-bit in-order pipeline that has a branch delay slot. When the pipeline signals a fault, it gives the fault kind, the PC of the faulting instruction, the next PC and, for a coprocessor fault, a coprocessor number. In one clock edge the controller updates its processor-state copies: the exception-level flag, the cause word (exception code, delay-slot flag, coprocessor field), the exception return address and the shadow register set selectors. In the cycle that follows it drives a one-cycle redirect strobe that carries the handler address and the two sequential fetch addresses after it.

The handler address depends on the exception base input, on the bootstrap-vector mode bit, on the vectored-interrupt mode bit and on the exception level held before entry. After a synchronous reset the controller redirects the pipeline to the fixed boot address. It also marks coprocessor 1 usable. While a redirect is being issued, it refuses new requests and raises `busy`.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous reset clears `status_exl`, `cause_bd`, `cause_code`, `cause_ce`, `epc` and both shadow-set fields, and sets `status_cu1` to 1. In the first cycle after `rst` falls, `redir_valid` is 1 for one cycle with PC 0xBFC00000, next PC 0xBFC00004 and next-next PC 0xBFC00008, and `busy` is 1.
- R2: `req_kind` encodes the fault, and `cause_code` is loaded as follows (kind -> code): 0 interrupt -> 0x0, 1 TLB modified -> 0x1, 2 TLB load invalid -> 0x2, 3 TLB store invalid -> 0x3, 4 TLB load refill -> 0x2, 5 TLB store refill -> 0x3, 6 load/fetch address error -> 0x4, 7 store address error -> 0x5, 8 syscall -> 0x8, 9 breakpoint -> 0x9, 10 reserved instruction -> 0xA, 11 coprocessor unusable -> 0xB, 12 overflow -> 0xC, 13 trap -> 0xD.
- R3: Every accepted request sets `status_exl` to 1, whether or not it was already 1.
- R4: When `req_pc`+4 differs from `req_npc`, `epc` becomes `req_pc`-4 and `cause_bd` becomes 1. Otherwise `epc` becomes `req_pc` and `cause_bd` becomes 0.
- R5: `cause_ce` becomes `req_cop` for kind 11 and 0 for every other accepted kind.
- R6: When `status_exl` and `mode_bev` are both 0 at acceptance, `srs_pss` takes the old `srs_css` and `srs_css` takes `srs_ess`. Otherwise both fields keep their values.
- R7: The handler address is `ebase`+0x180 for every kind that R8, R9 and R10 do not cover.
- R8: For kinds 4 and 5 (refill), the handler is `ebase`+0x000 when `status_exl` was 0 before entry and `ebase`+0x180 when it was 1.
- R9: For kind 0 (interrupt), the handler is `ebase`+0x200 when `mode_iv` is 1 and `ebase`+0x180 otherwise.
- R10: For kind 12 (overflow) with `mode_bev` at 1, the handler is 0xBFC00200.
- R11: A request accepted at a clock edge updates all state at that edge and makes `redir_valid` 1 for exactly the next cycle, with `redir_npc` = handler+4 and `redir_nnpc` = handler+8.
- R12: `busy` is 1 whenever `redir_valid` is 1. A request while `busy` is 1, or with `req_kind` 14 or 15, changes no state and produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle exception request |
| req_kind | input | 4 | Fault kind (R2 encoding) |
| req_pc | input | 32 | PC of the faulting instruction |
| req_npc | input | 32 | Next PC at the time of the fault |
| req_cop | input | 2 | Offending coprocessor number |
| ebase | input | 32 | Exception base address |
| mode_bev | input | 1 | Bootstrap vector mode bit |
| mode_iv | input | 1 | Vectored interrupt mode bit |
| srs_ess | input | 4 | Shadow set to use for exceptions |
| busy | output | 1 | Requests are not accepted |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | New PC |
| redir_npc | output | 32 | New next PC |
| redir_nnpc | output | 32 | New next-next PC |
| status_exl | output | 1 | Exception level flag |
| status_cu1 | output | 1 | Coprocessor 1 usable flag |
| cause_code | output | 5 | Exception code field |
| cause_bd | output | 1 | Fault was in a delay slot |
| cause_ce | output | 2 | Coprocessor number field |
| epc | output | 32 | Exception return address |
| srs_css | output | 4 | Current shadow set |
| srs_pss | output | 4 | Previous shadow set |

## Verification
Each state field is due one edge after the request edge, and so is the redirect strobe. The bench therefore drives each request on a falling edge, holds it for one cycle, and samples every output at the next falling edge. The reset redirect is due one edge after `rst` falls. It is sampled at the falling edge after the release, and the strobe is checked to be low again one cycle later. For the busy case the bench holds a second request over the redirect cycle and then reads the state one cycle later to show that nothing changed.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        K_INT           = 4'd0,
        K_TLB_MOD       = 4'd1,
        K_TLB_LD_INV    = 4'd2,
        K_TLB_ST_INV    = 4'd3,
        K_TLB_LD_REFILL = 4'd4,
        K_TLB_ST_REFILL = 4'd5,
        K_ADDR_LD       = 4'd6,
        K_ADDR_ST       = 4'd7,
        K_SYSCALL       = 4'd8,
        K_BREAK         = 4'd9,
        K_RSVD_INSN     = 4'd10,
        K_COP_UNUSABLE  = 4'd11,
        K_OVERFLOW      = 4'd12,
        K_TRAP          = 4'd13
    } exc_kind_e;

    localparam logic [3:0]  LAST_KIND    = 4'd13;
    localparam logic [11:0] OFS_REFILL   = 12'h000;
    localparam logic [11:0] OFS_GENERAL  = 12'h180;
    localparam logic [11:0] OFS_VEC_INT  = 12'h200;
    localparam int          INSN_BYTES   = 4;
    localparam int          CODE_W       = 5;
    localparam int          COP_W        = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bd;
        logic [COP_W-1:0]  ce;
    } cause_t;

    function automatic logic kind_known(input logic [3:0] k);
        return k <= LAST_KIND;
    endfunction

    function automatic logic kind_is_refill(input logic [3:0] k);
        return (k == K_TLB_LD_REFILL) || (k == K_TLB_ST_REFILL);
    endfunction

    function automatic logic [CODE_W-1:0] kind_code(input logic [3:0] k);
        logic [CODE_W-1:0] c;
        case (k)
            K_INT:           c = 5'h00;
            K_TLB_MOD:       c = 5'h01;
            K_TLB_LD_INV,
            K_TLB_LD_REFILL: c = 5'h02;
            K_TLB_ST_INV,
            K_TLB_ST_REFILL: c = 5'h03;
            K_ADDR_LD:       c = 5'h04;
            K_ADDR_ST:       c = 5'h05;
            K_SYSCALL:       c = 5'h08;
            K_BREAK:         c = 5'h09;
            K_RSVD_INSN:     c = 5'h0A;
            K_COP_UNUSABLE:  c = 5'h0B;
            K_OVERFLOW:      c = 5'h0C;
            K_TRAP:          c = 5'h0D;
            default:         c = 5'h00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] OVF_BEV_VEC = 32'hBFC0_0200
) (
    input  logic [3:0]      kind,
    input  logic [XLEN-1:0] ebase,
    input  logic            exl_before,
    input  logic            bev,
    input  logic            iv,
    output logic [XLEN-1:0] handler
);
    localparam int PAD = XLEN - 12;

    logic [11:0] offset;
    logic        use_fixed;

    always_comb begin
        use_fixed = 1'b0;
        offset    = OFS_GENERAL;
        if (kind_is_refill(kind)) begin
            offset = exl_before ? OFS_GENERAL : OFS_REFILL;
        end else if (kind == K_INT) begin
            offset = iv ? OFS_VEC_INT : OFS_GENERAL;
        end else if (kind == K_OVERFLOW) begin
            use_fixed = bev;
        end
    end

    assign handler = use_fixed ? OVF_BEV_VEC : (ebase + {{PAD{1'b0}}, offset});

endmodule

// File: rtl/exc_slot_detect.sv
module exc_slot_detect
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    output logic            in_slot,
    output logic [XLEN-1:0] ret_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assign in_slot  = (pc + STEP) != npc;
    assign ret_addr = in_slot ? (pc - STEP) : pc;

endmodule

// File: rtl/exc_srs_rotate.sv
module exc_srs_rotate #(
    parameter int SRS_W = 4
) (
    input  logic             exl_before,
    input  logic             bev,
    input  logic [SRS_W-1:0] css,
    input  logic [SRS_W-1:0] pss,
    input  logic [SRS_W-1:0] ess,
    output logic [SRS_W-1:0] css_next,
    output logic [SRS_W-1:0] pss_next
);
    logic rotate;

    assign rotate   = !exl_before && !bev;
    assign pss_next = rotate ? css : pss;
    assign css_next = rotate ? ess : css;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              SRS_W       = 4,
    parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] OVF_BEV_VEC = 32'hBFC0_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [XLEN-1:0]   req_npc,
    input  logic [COP_W-1:0]  req_cop,
    input  logic [XLEN-1:0]   ebase,
    input  logic              mode_bev,
    input  logic              mode_iv,
    input  logic [SRS_W-1:0]  srs_ess,
    output logic              busy,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   redir_npc,
    output logic [XLEN-1:0]   redir_nnpc,
    output logic              status_exl,
    output logic              status_cu1,
    output logic [CODE_W-1:0] cause_code,
    output logic              cause_bd,
    output logic [COP_W-1:0]  cause_ce,
    output logic [XLEN-1:0]   epc,
    output logic [SRS_W-1:0]  srs_css,
    output logic [SRS_W-1:0]  srs_pss
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

    cause_t          cause_q;
    logic            exl_q;
    logic            cu1_q;
    logic [XLEN-1:0] epc_q;
    logic [SRS_W-1:0] css_q, pss_q;
    logic            boot_pending_q;
    logic            rv_q;
    logic [XLEN-1:0] rpc_q, rnpc_q, rnnpc_q;

    logic            accept;
    logic [XLEN-1:0] handler;
    logic            in_slot;
    logic [XLEN-1:0] ret_addr;
    logic [SRS_W-1:0] css_next, pss_next;
    cause_t          cause_next;

    assign busy   = boot_pending_q | rv_q;
    assign accept = req_valid && !busy && kind_known(req_kind);

    exc_vector_sel #(
        .XLEN        (XLEN),
        .OVF_BEV_VEC (OVF_BEV_VEC)
    ) u_vec (
        .kind       (req_kind),
        .ebase      (ebase),
        .exl_before (exl_q),
        .bev        (mode_bev),
        .iv         (mode_iv),
        .handler    (handler)
    );

    exc_slot_detect #(
        .XLEN (XLEN)
    ) u_slot (
        .pc       (req_pc),
        .npc      (req_npc),
        .in_slot  (in_slot),
        .ret_addr (ret_addr)
    );

    exc_srs_rotate #(
        .SRS_W (SRS_W)
    ) u_srs (
        .exl_before (exl_q),
        .bev        (mode_bev),
        .css        (css_q),
        .pss        (pss_q),
        .ess        (srs_ess),
        .css_next   (css_next),
        .pss_next   (pss_next)
    );

    always_comb begin
        cause_next.code = kind_code(req_kind);
        cause_next.bd   = in_slot;
        cause_next.ce   = (req_kind == K_COP_UNUSABLE) ? req_cop : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q        <= '0;
            exl_q          <= 1'b0;
            cu1_q          <= 1'b1;
            epc_q          <= '0;
            css_q          <= '0;
            pss_q          <= '0;
            boot_pending_q <= 1'b1;
            rv_q           <= 1'b0;
            rpc_q          <= '0;
            rnpc_q         <= '0;
            rnnpc_q        <= '0;
        end else begin
            rv_q <= 1'b0;
            if (boot_pending_q) begin
                boot_pending_q <= 1'b0;
                rv_q           <= 1'b1;
                rpc_q          <= RESET_VEC;
                rnpc_q         <= RESET_VEC + STEP;
                rnnpc_q        <= RESET_VEC + STEP2;
            end else if (accept) begin
                cause_q <= cause_next;
                exl_q   <= 1'b1;
                epc_q   <= ret_addr;
                css_q   <= css_next;
                pss_q   <= pss_next;
                rv_q    <= 1'b1;
                rpc_q   <= handler;
                rnpc_q  <= handler + STEP;
                rnnpc_q <= handler + STEP2;
            end
        end
    end

    assign redir_valid = rv_q;
    assign redir_pc    = rpc_q;
    assign redir_npc   = rnpc_q;
    assign redir_nnpc  = rnnpc_q;
    assign status_exl  = exl_q;
    assign status_cu1  = cu1_q;
    assign cause_code  = cause_q.code;
    assign cause_bd    = cause_q.bd;
    assign cause_ce    = cause_q.ce;
    assign epc         = epc_q;
    assign srs_css     = css_q;
    assign srs_pss     = pss_q;

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SRS_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        req_kind,
    input logic [XLEN-1:0]   req_pc,
    input logic [XLEN-1:0]   req_npc,
    input logic              mode_bev,
    input logic              busy,
    input logic              redir_valid,
    input logic [XLEN-1:0]   redir_pc,
    input logic [XLEN-1:0]   redir_npc,
    input logic [XLEN-1:0]   redir_nnpc,
    input logic              status_exl,
    input logic [CODE_W-1:0] cause_code,
    input logic              cause_bd,
    input logic [COP_W-1:0]  cause_ce,
    input logic [XLEN-1:0]   epc,
    input logic [SRS_W-1:0]  srs_css,
    input logic [SRS_W-1:0]  srs_pss
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic taken;
    assign taken = req_valid && !busy && (req_kind <= LAST_KIND);

    a_r3_exl_set: assert property (@(posedge clk) disable iff (rst)
        taken |=> status_exl);

    a_r4_slot_epc: assert property (@(posedge clk) disable iff (rst)
        taken && ((req_pc + STEP) != req_npc) |=> cause_bd && (epc == $past(req_pc) - STEP));

    a_r4_seq_epc: assert property (@(posedge clk) disable iff (rst)
        taken && ((req_pc + STEP) == req_npc) |=> !cause_bd && (epc == $past(req_pc)));

    a_r5_ce_clear: assert property (@(posedge clk) disable iff (rst)
        taken && (req_kind != K_COP_UNUSABLE) |=> cause_ce == '0);

    a_r6_srs_hold: assert property (@(posedge clk) disable iff (rst)
        taken && (status_exl || mode_bev) |=> $stable(srs_css) && $stable(srs_pss));

    a_r11_redirect_step: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_npc == redir_pc + STEP) && (redir_nnpc == redir_npc + STEP));

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !redir_valid);

    a_r12_busy_strobe: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> busy);

    a_r12_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        req_valid && busy |=> $stable(epc) && $stable(cause_code) && $stable(srs_css));

endmodule

bind exc_entry_ctrl exc_entry_checker #(
    .XLEN  (XLEN),
    .SRS_W (SRS_W)
) u_exc_entry_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_pc      (req_pc),
    .req_npc     (req_npc),
    .mode_bev    (mode_bev),
    .busy        (busy),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .redir_npc   (redir_npc),
    .redir_nnpc  (redir_nnpc),
    .status_exl  (status_exl),
    .cause_code  (cause_code),
    .cause_bd    (cause_bd),
    .cause_ce    (cause_ce),
    .epc         (epc),
    .srs_css     (srs_css),
    .srs_pss     (srs_pss)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [31:0] req_pc = '0, req_npc = '0, ebase = '0;
    logic [1:0]  req_cop = '0;
    logic        mode_bev = 1'b0, mode_iv = 1'b0;
    logic [3:0]  srs_ess = '0;
    logic        busy, redir_valid, status_exl, status_cu1, cause_bd;
    logic [31:0] redir_pc, redir_npc, redir_nnpc, epc;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce;
    logic [3:0]  srs_css, srs_pss;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // model state
    logic        m_exl, m_bd;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [31:0] m_epc, m_hnd;
    logic [3:0]  m_css, m_pss;

    always #4 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_npc(req_npc), .req_cop(req_cop), .ebase(ebase),
        .mode_bev(mode_bev), .mode_iv(mode_iv), .srs_ess(srs_ess),
        .busy(busy), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_npc(redir_npc), .redir_nnpc(redir_nnpc), .status_exl(status_exl),
        .status_cu1(status_cu1), .cause_code(cause_code), .cause_bd(cause_bd),
        .cause_ce(cause_ce), .epc(epc), .srs_css(srs_css), .srs_pss(srs_pss)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(input int k);
        case (k)
            0: return 5'h0;   1: return 5'h1;   2: return 5'h2;   3: return 5'h3;
            4: return 5'h2;   5: return 5'h3;   6: return 5'h4;   7: return 5'h5;
            8: return 5'h8;   9: return 5'h9;   10: return 5'hA;  11: return 5'hB;
            12: return 5'hC;  13: return 5'hD;  default: return 5'h0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; req_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 boot strobe", 32'(redir_valid), 32'd1);
        chk("R1 boot pc", redir_pc, 32'hBFC0_0000);
        chk("R1 boot npc", redir_npc, 32'hBFC0_0004);
        chk("R1 boot nnpc", redir_nnpc, 32'hBFC0_0008);
        chk("R1 busy", 32'(busy), 32'd1);
        chk("R1 exl", 32'(status_exl), 32'd0);
        chk("R1 cu1", 32'(status_cu1), 32'd1);
        chk("R1 code/bd/ce", {25'd0, cause_code, cause_bd, cause_ce}, 32'd0);
        chk("R1 srs", {24'd0, srs_css, srs_pss}, 32'd0);
        m_exl = 0; m_bd = 0; m_code = 0; m_ce = 0; m_epc = 0; m_css = 0; m_pss = 0;
    endtask

    task automatic fire(input int k, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [1:0] cop, input logic bev, input logic iv,
                        input logic [3:0] ess, input logic [31:0] eb);
        logic ok;
        ok = (k <= 13);
        @(negedge clk);
        req_kind = 4'(k); req_pc = pc; req_npc = npc; req_cop = cop;
        mode_bev = bev; mode_iv = iv; srs_ess = ess; ebase = eb; req_valid = 1'b1;
        if (ok) begin
            if (k == 4 || k == 5)          m_hnd = m_exl ? eb + 32'h180 : eb;
            else if (k == 0)               m_hnd = iv ? eb + 32'h200 : eb + 32'h180;
            else if (k == 12 && bev)       m_hnd = 32'hBFC0_0200;
            else                           m_hnd = eb + 32'h180;
            if (!m_exl && !bev) begin m_pss = m_css; m_css = ess; end
            m_exl  = 1'b1;
            m_code = exp_code(k);
            m_bd   = (pc + 32'd4) != npc;
            m_epc  = m_bd ? pc - 32'd4 : pc;
            m_ce   = (k == 11) ? cop : 2'd0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(ok ? "R11 strobe" : "R12 unknown kind no strobe", 32'(redir_valid), 32'(ok));
        chk("R3 exl", 32'(status_exl), 32'(m_exl));
        chk("R2 code", 32'(cause_code), 32'(m_code));
        chk("R4 bd", 32'(cause_bd), 32'(m_bd));
        chk("R4 epc", epc, m_epc);
        chk("R5 ce", 32'(cause_ce), 32'(m_ce));
        chk("R6 css", 32'(srs_css), 32'(m_css));
        chk("R6 pss", 32'(srs_pss), 32'(m_pss));
        if (ok) begin
            if (k == 4 || k == 5)    chk("R8 refill handler", redir_pc, m_hnd);
            else if (k == 0)         chk("R9 interrupt handler", redir_pc, m_hnd);
            else if (k == 12 && bev) chk("R10 overflow bev handler", redir_pc, m_hnd);
            else                     chk("R7 general handler", redir_pc, m_hnd);
            chk("R11 npc", redir_npc, m_hnd + 32'd4);
            chk("R11 nnpc", redir_nnpc, m_hnd + 32'd8);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            for (int m = 0; m < 16; m++) begin
                logic [31:0] pc, npc;
                pc  = 32'h0040_0000 + 32'(k) * 32'h100 + 32'(m) * 32'h10;
                npc = m[3] ? pc + 32'h40 : pc + 32'd4;
                do_reset();
                if (m[0]) fire(8, 32'h0000_1000, 32'h0000_1004, 2'd0, 1'b0, 1'b0, 4'd5, 32'h9000_0000);
                fire(k, pc, npc, 2'(m), m[1], m[2], 4'((k + m) & 15), 32'h8000_0000 | (32'(m) << 12));
            end
        end

        // R12: request held over the redirect cycle is ignored
        do_reset();
        fire(8, 32'h0000_2000, 32'h0000_2004, 2'd0, 1'b0, 1'b0, 4'd3, 32'h8000_0000);
        chk("R12 busy during strobe", 32'(busy), 32'd1);
        req_kind = 4'd9; req_pc = 32'h0000_3000; req_npc = 32'h0000_3004; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 busy request no strobe", 32'(redir_valid), 32'd0);
        chk("R12 busy request code kept", 32'(cause_code), 32'h8);
        chk("R12 busy request epc kept", epc, 32'h0000_2000);
        chk("R12 busy clears", 32'(busy), 32'd0);
        fire(9, 32'h0000_3000, 32'h0000_3004, 2'd0, 1'b0, 1'b0, 4'd7, 32'h8000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule